// File: doc/BRIEF.md
# Per-Pin GPIO Edge and Level Interrupt Detector

This block watches a bank of already-synchronized GPIO pin levels and raises interrupt flags according to a detection mode chosen separately for every pin. Each pin owns one configuration word, and a 4-bit mode code in it selects one of these: no detection, active-low level, active-high level, rising edge, falling edge or either edge. Any detected event sets that pin's bit in a shared status word. Software clears a bit by writing a one to it. A single interrupt line is the OR of all status bits.

Software reaches the block through a simple register port: a 32-bit address, 32-bit write data, a write strobe and a read strobe, with read data returned in the same cycle. Edge sensing compares each pin's level in the current cycle with its level in the previous cycle. Level sensing re-asserts its flag on every cycle that the level persists, so a level flag can only be cleared once the pin has left the active level.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset every configuration word reads 0, the status word reads 0 and `irq_o` is low.
- R2: The configuration word of pin n is at byte address 4*n (0x00 to 0x7C). Only bits 19:16 (the mode code) are stored. These bits read back in place, and every other bit of the word reads 0.
- R3: With mode 0x8, a pin sampled low in a cycle sets its status bit, which is visible from the next cycle on.
- R4: With mode 0xC, a pin sampled high in a cycle sets its status bit, which is visible from the next cycle on.
- R5: With mode 0x9, a pin that was 0 in the previous cycle and is 1 now sets its status bit.
- R6: With mode 0xA, a pin that was 1 in the previous cycle and is 0 now sets its status bit.
- R7: With mode 0xB, any change of the pin level between consecutive cycles sets its status bit.
- R8: Mode 0x0 and every code other than 0x8, 0x9, 0xA, 0xB and 0xC never set a status bit.
- R9: The status word is at byte address 0xA0, with bit n belonging to pin n. Writing it clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: If a pin detects an event in the same cycle that its status bit is written with 1, the bit stays set.
- R11: `irq_o` is high exactly while at least one status bit is set.
- R12: Reads of any other address, including misaligned addresses below 0x80, return 0, and writes to them change no state. With `rd_en` low, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe; read data is valid in the same cycle |
| addr | input | 32 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; 0 when no register is selected |
| pin_in | input | 32 | Synchronized pin levels, bit n is pin n |
| irq_o | output | 1 | Combined interrupt, high while any status bit is set |

## Verification
Each status bit is a sticky register fed by a per-pin detector. A wrong mode register, a stale previous-level bit or a lost clear therefore shows up on `irq_o` and in a status read one cycle after the pin stimulus that exposes it. The bench reads the status word on almost every cycle and compares `irq_o` every cycle, so a bad flag is seen within one clock. Directed phases cover each mode and a clear that collides with an event. A longer mixed phase drives pseudo-random pins, random mode codes and random clears.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned NUM_PINS   = 32;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned MODE_W     = 4;
    localparam int unsigned MODE_LSB   = 16;
    localparam int unsigned CFG_STRIDE = 4;
    localparam int unsigned PIN_IDX_W  = $clog2(NUM_PINS);
    localparam logic [ADDR_W-1:0] STS_ADDR = 32'h0000_00A0;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 4'h0,
        MODE_LVL_LO = 4'h8,
        MODE_RISE   = 4'h9,
        MODE_FALL   = 4'hA,
        MODE_BOTH   = 4'hB,
        MODE_LVL_HI = 4'hC
    } irq_mode_e;

    typedef struct packed {
        logic lvl_lo;
        logic lvl_hi;
        logic rise;
        logic fall;
    } sense_t;

    typedef struct packed {
        logic                 cfg_hit;
        logic                 sts_hit;
        logic [PIN_IDX_W-1:0] idx;
    } addr_dec_t;

    function automatic sense_t decode_mode(logic [MODE_W-1:0] code);
        sense_t s;
        s = '0;
        case (code)
            MODE_LVL_LO: s.lvl_lo = 1'b1;
            MODE_LVL_HI: s.lvl_hi = 1'b1;
            MODE_RISE:   s.rise   = 1'b1;
            MODE_FALL:   s.fall   = 1'b1;
            MODE_BOTH: begin
                s.rise = 1'b1;
                s.fall = 1'b1;
            end
            default:     s = '0;
        endcase
        return s;
    endfunction

    function automatic addr_dec_t decode_addr(logic [ADDR_W-1:0] a, int unsigned npins);
        addr_dec_t d;
        d.cfg_hit = (a < ADDR_W'(npins * CFG_STRIDE)) && (a[1:0] == 2'b00);
        d.sts_hit = (a == STS_ADDR);
        d.idx     = a[2 +: PIN_IDX_W];
        return d;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = NUM_PINS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       hit,
    input  logic [PIN_IDX_W-1:0]       idx,
    input  logic [MODE_W-1:0]          mode_in,
    output logic [N-1:0][MODE_W-1:0]   modes_o
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [MODE_W-1:0] mode_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q <= '0;
            end else if (wr_en && hit && (idx == PIN_IDX_W'(g))) begin
                mode_q <= mode_in;
            end
        end

        assign modes_o[g] = mode_q;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = NUM_PINS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N-1:0]             pin_in,
    input  logic [N-1:0][MODE_W-1:0] modes,
    output logic [N-1:0]             evt_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= pin_in;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_pin
        sense_t sense;
        always_comb begin
            sense    = decode_mode(modes[g]);
            evt_o[g] = (sense.lvl_lo & ~pin_in[g])
                     | (sense.lvl_hi &  pin_in[g])
                     | (sense.rise   &  pin_in[g] & ~prev_q[g])
                     | (sense.fall   & ~pin_in[g] &  prev_q[g]);
        end
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = NUM_PINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
        end else begin
            flags_o <= (flags_o & ~clr) | evt;
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = NUM_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N-1:0]      pin_in,
    output logic              irq_o
);

    addr_dec_t                 dec;
    logic [N-1:0][MODE_W-1:0]  modes;
    logic [N-1:0]              evt;
    logic [N-1:0]              clr;
    logic [N-1:0]              flags;

    assign dec = decode_addr(addr, N);
    assign clr = (wr_en && dec.sts_hit) ? wdata[N-1:0] : '0;

    gpio_irq_cfg #(.N(N)) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .hit     (dec.cfg_hit),
        .idx     (dec.idx),
        .mode_in (wdata[MODE_LSB +: MODE_W]),
        .modes_o (modes)
    );

    gpio_irq_detect #(.N(N)) det_i (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .modes  (modes),
        .evt_o  (evt)
    );

    gpio_irq_status #(.N(N)) sts_i (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .clr     (clr),
        .flags_o (flags)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (dec.cfg_hit) begin
                rdata[MODE_LSB +: MODE_W] = modes[dec.idx];
            end else if (dec.sts_hit) begin
                rdata[N-1:0] = flags;
            end
        end
    end

    assign irq_o = |flags;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = NUM_PINS
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [DATA_W-1:0]        wdata,
    input logic [N-1:0]             pin_in,
    input logic                     irq_o,
    input logic [N-1:0][MODE_W-1:0] modes,
    input logic [N-1:0]             evt,
    input logic [N-1:0]             flags
);

    // R1: flags are clear in the first cycle after reset is released
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flags == '0 && !irq_o));

    // R9: a written one clears its bit unless a new event arrived
    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == STS_ADDR) |=> ((flags & $past(wdata[N-1:0]) & ~$past(evt)) == '0));

    // R10: an event always leaves its flag set, clear or not
    p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    // R11: the interrupt can only rise after some detector fired
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(evt) != '0));

    for (genvar g = 0; g < N; g++) begin : g_pin
        // R3: level-low pin low sets its flag
        p_lvl_lo_r3: assert property (@(posedge clk) disable iff (rst)
            (modes[g] == 4'h8 && !pin_in[g]) |=> flags[g]);

        // R4: level-high pin high sets its flag
        p_lvl_hi_r4: assert property (@(posedge clk) disable iff (rst)
            (modes[g] == 4'hC && pin_in[g]) |=> flags[g]);

        // R5: a 0-to-1 step in rising mode sets its flag
        p_rise_r5: assert property (@(posedge clk) disable iff (rst)
            (modes[g] == 4'h9 && pin_in[g] && !$past(pin_in[g])) |=> flags[g]);

        // R8: unlisted or disabled codes never raise a clear flag
        p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
            (!(modes[g] inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC}) && !flags[g]) |=> !flags[g]);
    end

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(N)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .pin_in (pin_in),
    .irq_o  (irq_o),
    .modes  (modes),
    .evt    (evt),
    .flags  (flags)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic        irq_o;

    int vectors = 0;
    int miscompares = 0;
    bit timed_out = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl dut_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .pin_in (pin_in),
        .irq_o  (irq_o)
    );

    // behavioural reference model
    logic [3:0]  m_mode [32];
    logic [31:0] m_sts;
    logic [31:0] m_prev;

    always @(posedge clk) begin
        logic [31:0] ev;
        logic [31:0] clrm;
        if (rst) begin
            for (int i = 0; i < 32; i++) m_mode[i] = 4'h0;
            m_sts  = '0;
            m_prev = '0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                case (m_mode[i])
                    4'h8:    ev[i] = !pin_in[i];
                    4'hC:    ev[i] = pin_in[i];
                    4'h9:    ev[i] = pin_in[i] && !m_prev[i];
                    4'hA:    ev[i] = !pin_in[i] && m_prev[i];
                    4'hB:    ev[i] = pin_in[i] != m_prev[i];
                    default: ev[i] = 1'b0;
                endcase
            end
            clrm  = (wr_en && addr == 32'hA0) ? wdata : 32'h0;
            m_sts = (m_sts & ~clrm) | ev;
            if (wr_en && addr < 32'h80 && addr[1:0] == 2'b00)
                m_mode[addr[6:2]] = wdata[19:16];
            m_prev = pin_in;
        end
    end

    function automatic logic [31:0] exp_rdata();
        if (!rd_en) return 32'h0;
        if (addr == 32'hA0) return m_sts;
        if (addr < 32'h80 && addr[1:0] == 2'b00) return {12'h0, m_mode[addr[6:2]], 16'h0};
        return 32'h0;
    endfunction

    task automatic check_now(string tag);
        logic [31:0] er;
        logic        ei;
        er = exp_rdata();
        ei = (m_sts != 32'h0);
        vectors++;
        if (irq_o !== ei) begin
            miscompares++;
            $display("FAIL %s/R11 irq_o got %0b expected %0b", tag, irq_o, ei);
        end
        vectors++;
        if (rdata !== er) begin
            miscompares++;
            $display("FAIL %s rdata got %08h expected %08h (addr %08h)", tag, rdata, er, addr);
        end
    endtask

    task automatic step(input bit w, input bit r, input logic [31:0] a,
                        input logic [31:0] d, input logic [31:0] p, input string tag);
        @(negedge clk);
        wr_en  = w;
        rd_en  = r;
        addr   = a;
        wdata  = d;
        pin_in = p;
        #1;
        check_now(tag);
    endtask

    task automatic run_all();
        logic [31:0] lfsr;
        logic [31:0] pins;
        logic [3:0]  codes [8];
        codes[0] = 4'h0; codes[1] = 4'h8; codes[2] = 4'h9; codes[3] = 4'hA;
        codes[4] = 4'hB; codes[5] = 4'hC; codes[6] = 4'h3; codes[7] = 4'hF;
        pins = 32'hFFFF_FFFF;

        repeat (3) @(negedge clk);
        // R1: reset values observed while reset is still high, then released
        step(0, 1, 32'hA0, 0, pins, "R1");
        @(negedge clk);
        rst = 1'b0;
        step(0, 1, 32'h0C, 0, pins, "R1");
        step(0, 1, 32'hA0, 0, pins, "R1");

        // R2: mode writes with surrounding bits set
        step(1, 0, 32'h00, 32'h0008_0000, pins, "R2");
        step(1, 0, 32'h04, 32'hFFFC_FFFF, pins, "R2");
        step(1, 0, 32'h08, 32'h0009_0000, pins, "R2");
        step(1, 0, 32'h0C, 32'h000A_0000, pins, "R2");
        step(1, 0, 32'h10, 32'h000B_0000, pins, "R2");
        step(1, 0, 32'h14, 32'h0000_0000, pins, "R2");
        step(1, 0, 32'h18, 32'h0005_0000, pins, "R8");
        step(1, 0, 32'h1C, 32'hFFFF_FFFF, pins, "R8");
        for (int i = 0; i < 8; i++) step(0, 1, 32'(i * 4), 0, pins, "R2");

        // R12: unmapped and misaligned accesses
        step(1, 0, 32'h84, 32'hFFFF_FFFF, pins, "R12");
        step(1, 0, 32'h06, 32'hFFFF_FFFF, pins, "R12");
        step(0, 1, 32'h84, 0, pins, "R12");
        step(0, 1, 32'h06, 0, pins, "R12");
        step(0, 0, 32'hA0, 0, pins, "R12");
        step(0, 1, 32'h00, 0, pins, "R12");
        step(0, 1, 32'h18, 0, pins, "R12");

        // R4: pin1 high keeps re-arming its flag
        step(1, 1, 32'hA0, 32'hFFFF_FFFF, pins, "R4");
        step(0, 1, 32'hA0, 0, pins, "R4");
        // R9: written zeros keep bits, then clear all with pins quiet
        pins = 32'hFFFF_FFFD;
        step(1, 1, 32'hA0, 32'h0000_0000, pins, "R9");
        step(1, 1, 32'hA0, 32'hFFFF_FFFF, pins, "R9");
        step(0, 1, 32'hA0, 0, pins, "R9");

        // R6, R7, R3: all low -> falls on pins 3,4, level-low on pin 0
        pins = 32'h0;
        step(0, 1, 32'hA0, 0, pins, "R6");
        step(0, 1, 32'hA0, 0, pins, "R7");
        step(1, 1, 32'hA0, 32'hFFFF_FFFE, pins, "R3");
        step(0, 1, 32'hA0, 0, pins, "R3");
        // R5, R7: all high -> rises on pins 2,4; pins 5,6,7 stay quiet (R8)
        pins = 32'hFFFF_FFFD;
        step(0, 1, 32'hA0, 0, pins, "R5");
        step(0, 1, 32'hA0, 0, pins, "R8");
        // R10: pin 0 held low while its bit is cleared
        pins = 32'hFFFF_FFFC;
        step(1, 1, 32'hA0, 32'hFFFF_FFFF, pins, "R10");
        step(1, 1, 32'hA0, 32'h0000_0001, pins, "R10");
        step(0, 1, 32'hA0, 0, pins, "R10");
        pins = 32'hFFFF_FFFD;
        step(1, 1, 32'hA0, 32'hFFFF_FFFF, pins, "R10");
        step(0, 1, 32'hA0, 0, pins, "R11");

        // mixed: random modes on all pins, random pins and clears
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 32; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(1, 0, 32'(i * 4), {12'h0, codes[lfsr[2:0]], 16'h0}, pins, "R2");
        end
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[5:3] == 3'b000) pins = pins ^ lfsr;
            if (k % 5 == 4)
                step(1, 1, 32'hA0, {lfsr[15:0], lfsr[31:16]}, pins, "R9");
            else if (k % 7 == 3)
                step(0, 1, 32'(lfsr[4:0]) << 2, 0, pins, "R2");
            else
                step(0, 1, 32'hA0, 0, pins, "R7");
        end
        step(1, 0, 32'hA0, 32'hFFFF_FFFF, pins, "R9");
        step(0, 1, 32'hA0, 0, pins, "R11");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (50000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule